// File: doc/BRIEF.md
# One-Time-Programmable Byte ROM Pin Interface

This block is a synthesizable behavioural model of a byte-wide, one-time-programmable read-only memory of 8192 bytes, seen through the control pins of the part. A 13-bit address selects a byte. The bidirectional data bus is split into a data-in byte, a registered data-out byte and a registered drive enable. Three active-low strobes select the operation: chip select, output enable and program strobe. Two digital flags stand in for analog levels. One marks the programming supply as raised. The other marks the identifier level on address line 9.

With the supply flag low, the block reads. It returns either array data or one of two fixed identifier bytes, and each identifier byte has odd parity with bit 7 as the parity bit. With the supply flag high, the block programs or verifies. Programming can only clear bits, so the stored byte becomes the bitwise AND of the old byte and the new byte. When chip select is high, the outputs are always off and no write can happen. Several devices can therefore share every input except chip select and still be given different data.

A bulk-erase request walks the array one address per clock and sets every byte to 0xFF. A busy output stays high for the whole walk. The same walk runs after reset, so the first use of the block sees an erased array. Every result is registered: the data bus and its drive enable reflect the pins sampled at the previous rising clock edge.

Top module: `otp_rom_port`

## Requirements
- R1: While reset is held, busy is 1 and dq_oe is 0. After reset is released, busy stays 1 for exactly 8192 rising edges while every byte is set to 0xFF, and every byte then reads 0xFF.
- R2: With ce_n=0, oe_n=0 and vpp_hi=0, and with no identifier match, the next cycle has dq_oe=1 and dq_out equal to the byte at the sampled address. pgm_n has no effect in this mode.
- R3: With ce_n=0 and oe_n=1, and no program strobe under a raised supply, the next cycle has dq_oe=0 and dq_out=0x00.
- R4: With ce_n=1 (standby), the next cycle has dq_oe=0, whatever the levels of oe_n, pgm_n and vpp_hi. Two devices whose only differing input is ce_n never drive the bus in the same cycle.
- R5: With vpp_hi=1, ce_n=0 and pgm_n=0, the addressed byte becomes the old byte AND dq_in. A bit at 0 never returns to 1 through programming, and dq_oe is 0 in the next cycle.
- R6: With vpp_hi=1, pgm_n=0 and ce_n=1, the array is left unchanged (program inhibit).
- R7: With vpp_hi=1, ce_n=0, pgm_n=1 and oe_n=0, the next cycle drives the stored byte (verify). This includes a byte written by a program in the cycle just before.
- R8: A read with id_hv=1 has its address checked on every bit except bit 0 and bit 9 (mask 0x1DFE). If all those bits are 0, the read returns the maker byte 0x01 when addr[0]=0 and the part byte 0x8F when addr[0]=1. If any of those bits is 1, the read returns array data.
- R9: Each identifier byte has an odd number of ones, with bit 7 set or cleared to make the parity odd.
- R10: A 1 on erase_req while busy is 0 raises busy at the next edge. Busy then stays 1 for exactly 8192 rising edges, and afterwards every byte reads 0xFF. An erase_req during busy is ignored and does not restart the walk.
- R11: While busy is 1, dq_oe stays 0 and program strobes are ignored, including a strobe on the last cycle of the walk. A program strobe in the same cycle as an accepted erase_req is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; starts the erase walk |
| addr | input | 13 | Byte address |
| dq_in | input | 8 | Data bus, inbound byte for programming |
| dq_out | output | 8 | Data bus, registered outbound byte (0x00 when not driven) |
| dq_oe | output | 1 | Registered data-bus drive enable |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identifier level present on address line 9 |
| erase_req | input | 1 | Bulk-erase request |
| busy | output | 1 | Erase walk in progress |

## Verification
Two functions can land on the same clock edge: the erase walk and a program strobe. The bench provokes this in two places. It raises erase_req together with a full program strobe, and it holds a program strobe to address 3 with data 0x00 on the final edge of the walk. It also asks for a read early in the walk and re-requests erase in the middle of it. The result is judged by reading the addresses back once busy falls: address 3 must still read 0xFF, and the next program must then take effect at once. A per-clock reference model checks the drive enable and busy on every cycle in between.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PM_STANDBY,
    PM_OFF,
    PM_READ,
    PM_IDENT,
    PM_PROGRAM,
    PM_VERIFY
  } pin_mode_e;

  // Seven payload bits plus a top bit that makes the count of ones odd.
  function automatic logic [BYTE_W-1:0] odd_code(input logic [BYTE_W-2:0] low);
    return {~(^low), low};
  endfunction

  // Programming may only clear bits.
  function automatic logic [BYTE_W-1:0] clear_merge(input logic [BYTE_W-1:0] old_b,
                                                    input logic [BYTE_W-1:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/otp_rom_decode.sv
module otp_rom_decode
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int ID_LINE = 9
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  output pin_mode_e         mode
);

  localparam logic [ADDR_W-1:0] ID_FREE =
    ADDR_W'(1) | (ADDR_W'(1) << ID_LINE);

  logic id_addr_ok;
  assign id_addr_ok = ((addr & ~ID_FREE) == '0);

  always_comb begin
    if (ce_n) begin
      mode = PM_STANDBY;
    end else if (vpp_hi) begin
      if (!pgm_n)      mode = PM_PROGRAM;
      else if (!oe_n)  mode = PM_VERIFY;
      else             mode = PM_OFF;
    end else if (!oe_n) begin
      mode = (id_hv && id_addr_ok) ? PM_IDENT : PM_READ;
    end else begin
      mode = PM_OFF;
    end
  end

endmodule

// File: rtl/otp_rom_sweep.sv
module otp_rom_sweep #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req,
  output logic              busy,
  output logic              erase_go,
  output logic              sweep_we,
  output logic [ADDR_W-1:0] sweep_ptr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  assign erase_go = erase_req && !busy;
  assign sweep_we = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      sweep_ptr <= '0;
    end else if (busy) begin
      sweep_ptr <= sweep_ptr + ADDR_W'(1);
      if (sweep_ptr == LAST_ADDR) busy <= 1'b0;
    end else if (erase_go) begin
      busy      <= 1'b1;
      sweep_ptr <= '0;
    end
  end

endmodule

// File: rtl/otp_rom_cells.sv
module otp_rom_cells #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/otp_rom_port.sv
module otp_rom_port
  import otp_rom_pkg::*;
#(
  parameter int              ADDR_W  = 13,
  parameter int              ID_LINE = 9,
  parameter logic [BYTE_W-2:0] MFR_LOW = 7'h01,
  parameter logic [BYTE_W-2:0] DEV_LOW = 7'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] dq_in,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              erase_req,
  output logic              busy
);

  localparam logic [BYTE_W-1:0] MFR_CODE = odd_code(MFR_LOW);
  localparam logic [BYTE_W-1:0] DEV_CODE = odd_code(DEV_LOW);
  localparam logic [BYTE_W-1:0] ERASED   = '1;

  pin_mode_e         mode;
  logic              erase_go;
  logic              sweep_we;
  logic [ADDR_W-1:0] sweep_ptr;
  logic              quiet;
  logic              prog_fire;
  logic              rd_fire;
  logic              id_hit;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] cell_q;
  logic [BYTE_W-1:0] rd_byte;

  otp_rom_decode #(.ADDR_W(ADDR_W), .ID_LINE(ID_LINE)) u_decode (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .id_hv  (id_hv),
    .addr   (addr),
    .mode   (mode)
  );

  otp_rom_sweep #(.ADDR_W(ADDR_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_req (erase_req),
    .busy      (busy),
    .erase_go  (erase_go),
    .sweep_we  (sweep_we),
    .sweep_ptr (sweep_ptr)
  );

  // Erase activity (running or just accepted) pre-empts every pin operation.
  assign quiet     = busy | erase_go;
  assign prog_fire = (mode == PM_PROGRAM) && !quiet;
  assign rd_fire   = ((mode == PM_READ) || (mode == PM_IDENT) || (mode == PM_VERIFY)) && !quiet;
  assign id_hit    = rd_fire && (mode == PM_IDENT);

  assign wr_en   = sweep_we | prog_fire;
  assign wr_addr = sweep_we ? sweep_ptr : addr;
  assign wr_data = sweep_we ? ERASED : clear_merge(cell_q, dq_in);

  otp_rom_cells #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_cells (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (addr),
    .rdata (cell_q)
  );

  assign rd_byte = id_hit ? (addr[0] ? DEV_CODE : MFR_CODE) : cell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= rd_fire;
      dq_out <= rd_fire ? rd_byte : '0;
    end
  end

endmodule

// File: rtl/otp_rom_port_chk.sv
module otp_rom_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       busy,
  input logic       dq_oe,
  input logic [7:0] dq_out,
  input logic       prog_fire,
  input logic       rd_fire,
  input logic       id_hit,
  input logic       erase_go
);

  // R4
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_oe);

  // R3
  out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !prog_fire) |=> !dq_oe);

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dq_oe);

  // R11
  prog_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |-> !busy);

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |-> !ce_n);

  // R10
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> busy);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> dq_oe);

  // R9
  id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |=> (dq_oe && (^dq_out)));

endmodule

bind otp_rom_port otp_rom_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .busy      (busy),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .prog_fire (prog_fire),
  .rd_fire   (rd_fire),
  .id_hit    (id_hit),
  .erase_go  (erase_go)
);

// File: tb/otp_rom_port_test.sv
`timescale 1ns/1ps
module otp_rom_port_test;

  localparam int          NWORDS = 8192;
  localparam logic [7:0]  MFR    = 8'h01;
  localparam logic [7:0]  DEV    = 8'h8F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic        ce_n = 1'b1, ce_b = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic        vpp_hi = 1'b0, id_hv = 1'b0, erase_req = 1'b0;
  logic [7:0]  dq_out, dq_out_b;
  logic        dq_oe, dq_oe_b, busy, busy_b;

  int    checks = 0;
  int    errors = 0;
  string tag_now = "R1";

  always #2 clk = ~clk;

  otp_rom_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .erase_req(erase_req), .busy(busy));

  otp_rom_port uut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out_b),
    .dq_oe(dq_oe_b), .ce_n(ce_b), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .erase_req(erase_req), .busy(busy_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: erased-array contents, walk position, registered bus.
  logic [7:0] ref_mem [NWORDS];
  int         ref_pos = 0;
  bit         ref_busy = 1'b1;
  bit         ref_oe = 1'b0;
  logic [7:0] ref_out = 8'h00;
  string      ref_tag = "R1";

  always @(posedge clk) begin
    ref_tag = tag_now;
    ref_oe  = 1'b0;
    ref_out = 8'h00;
    if (!rst_n) begin
      ref_busy = 1'b1;
      ref_pos  = 0;
    end else if (ref_busy) begin
      ref_mem[ref_pos] = 8'hFF;
      ref_pos++;
      if (ref_pos == NWORDS) ref_busy = 1'b0;
    end else if (erase_req) begin
      ref_busy = 1'b1;
      ref_pos  = 0;
    end else if (!ce_n) begin
      if (vpp_hi) begin
        if (!pgm_n) ref_mem[addr] = ref_mem[addr] & dq_in;
        else if (!oe_n) begin ref_oe = 1'b1; ref_out = ref_mem[addr]; end
      end else if (!oe_n) begin
        ref_oe = 1'b1;
        if (id_hv && ((addr & 13'h1DFE) == 13'h0)) ref_out = addr[0] ? DEV : MFR;
        else ref_out = ref_mem[addr];
      end
    end
  end

  always @(negedge clk) begin
    check(ref_tag, {22'd0, busy, dq_oe, dq_out}, {22'd0, ref_busy, ref_oe, ref_out});
    checks++;
    if (dq_oe && dq_oe_b) begin
      errors++;
      $display("FAIL R4 both devices drive actual=1 expected=0");
    end
  end

  task automatic step(input logic [12:0] a, input logic [7:0] d, input logic ce,
                      input logic oe, input logic pg, input logic hv, input logic idf,
                      input logic er, input string tag);
    addr = a; dq_in = d; ce_n = ce; oe_n = oe; pgm_n = pg;
    vpp_hi = hv; id_hv = idf; erase_req = er; tag_now = tag;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(13'h0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [12:0] a, input logic idf, input logic [7:0] exp, input string tag);
    step(a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, idf, 1'b0, tag);
    check(tag, {31'd0, dq_oe}, 32'd1);
    check(tag, {24'd0, dq_out}, {24'd0, exp});
  endtask

  task automatic prog(input logic [12:0] a, input logic [7:0] d, input string tag);
    step(a, d, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, tag);
    check(tag, {31'd0, dq_oe}, 32'd0);
  endtask

  task automatic vfy(input logic [12:0] a, input logic [7:0] exp, input string tag);
    step(a, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, tag);
    check(tag, {24'd0, dq_out}, {24'd0, exp});
  endtask

  initial begin
    #(60000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset busy", {31'd0, busy}, 32'd1);
    check("R1 reset oe", {31'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R1 walk length", n, NWORDS);

    rd(13'h0000, 1'b0, 8'hFF, "R1");
    rd(13'h0064, 1'b0, 8'hFF, "R2");
    rd(13'h1FFF, 1'b0, 8'hFF, "R2");

    rd(13'h0000, 1'b1, MFR, "R8");
    check("R9 maker parity", $countones(dq_out) % 2, 1);
    rd(13'h0001, 1'b1, DEV, "R8");
    check("R9 part parity", $countones(dq_out) % 2, 1);
    rd(13'h0201, 1'b1, DEV, "R8");
    rd(13'h0003, 1'b1, 8'hFF, "R8");

    prog(13'h0005, 8'hA5, "R5");
    vfy(13'h0005, 8'hA5, "R7");
    prog(13'h0005, 8'h5A, "R5");
    vfy(13'h0005, 8'h00, "R5");
    prog(13'h0005, 8'hFF, "R5");
    vfy(13'h0005, 8'h00, "R5");
    prog(13'h0006, 8'hF0, "R5");
    prog(13'h0006, 8'h3C, "R5");
    vfy(13'h0006, 8'h30, "R7");
    rd(13'h0006, 1'b0, 8'h30, "R2");

    step(13'h0007, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    vfy(13'h0007, 8'hFF, "R6");

    prog(13'h000A, 8'h12, "R6");
    ce_b = 1'b0;
    step(13'h000A, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    ce_b = 1'b1;
    check("R6 other device", {23'd0, dq_oe_b, dq_out_b}, {23'd0, 1'b1, 8'hFF});
    check("R4 standby", {31'd0, dq_oe}, 32'd0);
    vfy(13'h000A, 8'h12, "R7");

    step(13'h0005, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    check("R4 standby oe low", {31'd0, dq_oe}, 32'd0);
    step(13'h0005, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    check("R3 disable", {24'd0, dq_out}, 32'd0);
    step(13'h0005, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    check("R3 disable raised supply", {31'd0, dq_oe}, 32'd0);
    rd(13'h0005, 1'b0, 8'h00, "R2");

    step(13'h0009, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
    n = 0;
    while (busy) begin
      n++;
      if (n == 3)
        step(13'h0005, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
      else if (n == 100)
        step(13'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
      else if (n == NWORDS)
        step(13'h0003, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
      else
        idle("R10");
    end
    check("R10 walk length", n, NWORDS);
    idle("R10");
    rd(13'h0003, 1'b0, 8'hFF, "R11");
    rd(13'h0009, 1'b0, 8'hFF, "R11");
    rd(13'h0005, 1'b0, 8'hFF, "R10");
    rd(13'h0006, 1'b0, 8'hFF, "R10");
    rd(13'h1FFF, 1'b0, 8'hFF, "R10");
    prog(13'h0003, 8'h0F, "R5");
    vfy(13'h0003, 8'h0F, "R7");
    idle("R3");
    idle("R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule